// File: doc/BRIEF.md
# Two-Tank Pump Hysteresis Controller

This block decides when a transfer pump lifting water from a lower cistern into an upper tank may run. Each vessel reports two binary water-present levels, a high one and a low one. The controller applies hysteresis on both vessels, so a single sensor that toggles near its threshold cannot make the pump short-cycle.

On the tank side, a pumping run begins only once the tank's low sensor reads dry. The run ends as soon as the tank's high sensor reads wet. On the cistern side, a run may continue while the level sits between the two cistern sensors. Once the cistern has been drained, a lockout holds the pump off until the cistern has filled completely again.

Every sensor input passes through a two-flop synchroniser and a stable-count filter before the state machine acts on it. The filter length is set at run time. A physically impossible reading, in which a high sensor is wet while the low sensor of the same vessel is dry, raises a fault and forces the pump off.

Top module: `pump_ctrl`

## Requirements
- R1: After reset, pump_on_o is 0, lockout_o is 1 and fault_o is 0.
- R2: With dwell_i = D ≥ 1, a level change on a sensor input driven just after edge 0 first affects the outputs at edge D+3 and not before. This covers two synchroniser stages, D filter cycles and one state register.
- R3: A change on a sensor input that lasts fewer than dwell_i cycles is ignored, and the outputs keep their previous values.
- R4: While the pump is off, it starts when the tank low sensor reads dry and the cistern lockout is released.
- R5: While the pump is running, it stops when the tank high sensor reads wet.
- R6: While the pump is off and the tank level lies between its sensors (low wet, high dry), the pump stays off.
- R7: While the pump is running and the cistern level lies between its sensors (low wet, high dry), the pump keeps running.
- R8: When the cistern low sensor reads dry, lockout_o goes to 1 and the pump stops.
- R9: While lockout_o is 1, a wet cistern low sensor alone does not release it. Only a wet cistern high sensor sets lockout_o to 0.
- R10: When either vessel reads high wet with low dry, fault_o goes to 1, the pump is forced off and lockout_o holds its value. fault_o returns to 0 once that reading clears.
- R11: dwell_i = 0 behaves the same as dwell_i = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dwell_i | input | CNT_W | Number of consecutive cycles a new sensor level must persist before it is accepted |
| tank_hi_i | input | 1 | Upper tank high sensor, 1 = water present |
| tank_lo_i | input | 1 | Upper tank low sensor, 1 = water present |
| cis_hi_i | input | 1 | Cistern high sensor, 1 = water present |
| cis_lo_i | input | 1 | Cistern low sensor, 1 = water present |
| pump_on_o | output | 1 | Pump enable |
| lockout_o | output | 1 | Cistern lockout active |
| fault_o | output | 1 | Impossible sensor combination seen |

## Verification
The bench resets the block and then applies every ordered pair of the sixteen sensor vectors. This separates start from hold, stop from continue, and lockout set from release, and it reaches every fault entry and exit from both a locked and a released state.

Directed fill and drain cycles check the two hysteresis bands separately: a tank refilling between its sensors and a cistern draining between its sensors. Exact-edge latency runs at dwell 3 and at dwell 0 check the synchroniser and filter depth. A pulse one cycle shorter than the dwell must leave the pump untouched.

// File: rtl/pump_pkg.sv
package pump_pkg;
  localparam int unsigned NUM_SENSORS = 4;
  // bit positions of the sensor vector
  localparam int unsigned IDX_CIS_LO  = 0;
  localparam int unsigned IDX_CIS_HI  = 1;
  localparam int unsigned IDX_TANK_LO = 2;
  localparam int unsigned IDX_TANK_HI = 3;

  typedef struct packed {
    logic tank_hi;
    logic tank_lo;
    logic cis_hi;
    logic cis_lo;
  } levels_t;
endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dwell_filter.sv
module dwell_filter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] dwell_i,
  input  logic             raw_i,
  output logic             level_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             level_q;
  logic             accept;

  // zero dwell treated as one
  assign accept = ({1'b0, cnt_q} + 1'b1) >= {1'b0, dwell_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (raw_i == level_q) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q   <= '0;
      level_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;

  // R3: accepted level only moves toward a differing raw value
  a_r3_move_only_on_diff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> ($past(raw_i) != $past(level_q)));
  // R3: agreement resets the run
  a_r3_agree_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == level_q) |=> $stable(level_q));
endmodule

// File: rtl/pump_fsm.sv
module pump_fsm
  import pump_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  levels_t lvl_i,
  output logic    pump_o,
  output logic    lock_o,
  output logic    fault_o
);
  logic pump_q, lock_q, fault_q;
  logic bad, lock_n, pump_n;

  assign bad = (lvl_i.tank_hi & ~lvl_i.tank_lo) | (lvl_i.cis_hi & ~lvl_i.cis_lo);

  always_comb begin
    if (lvl_i.cis_hi)      lock_n = 1'b0;
    else if (!lvl_i.cis_lo) lock_n = 1'b1;
    else                    lock_n = lock_q;

    if (pump_q) pump_n = ~(lvl_i.tank_hi | lock_n);
    else        pump_n = ~lvl_i.tank_lo & ~lock_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pump_q  <= 1'b0;
      lock_q  <= 1'b1;
      fault_q <= 1'b0;
    end else if (bad) begin
      pump_q  <= 1'b0;
      fault_q <= 1'b1;
    end else begin
      pump_q  <= pump_n;
      lock_q  <= lock_n;
      fault_q <= 1'b0;
    end
  end

  assign pump_o  = pump_q;
  assign lock_o  = lock_q;
  assign fault_o = fault_q;

  a_r10_fault_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> (fault_q && !pump_q && $stable(lock_q)));
  a_r5_stop_on_tank_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pump_q && lvl_i.tank_hi) |=> !pump_q);
  a_r4_start_needs_dry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pump_q) |-> ($past(!lvl_i.tank_lo) && !lock_q));
  a_r9_release_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(lvl_i.cis_hi));
  a_r8_lock_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i.cis_lo && !bad) |=> (lock_q && !pump_q));
endmodule

// File: rtl/pump_ctrl.sv
module pump_ctrl
  import pump_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] dwell_i,
  input  logic             tank_hi_i,
  input  logic             tank_lo_i,
  input  logic             cis_hi_i,
  input  logic             cis_lo_i,
  output logic             pump_on_o,
  output logic             lockout_o,
  output logic             fault_o
);
  logic [NUM_SENSORS-1:0] raw, synced, stable;
  levels_t                lvl;

  assign raw[IDX_CIS_LO]  = cis_lo_i;
  assign raw[IDX_CIS_HI]  = cis_hi_i;
  assign raw[IDX_TANK_LO] = tank_lo_i;
  assign raw[IDX_TANK_HI] = tank_hi_i;

  for (genvar i = 0; i < NUM_SENSORS; i++) begin : g_sense
    level_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[i]),
      .q_o   (synced[i])
    );
    dwell_filter #(.CNT_W(CNT_W)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .dwell_i(dwell_i),
      .raw_i  (synced[i]),
      .level_o(stable[i])
    );
  end

  assign lvl = levels_t'(stable);

  pump_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .pump_o (pump_on_o),
    .lock_o (lockout_o),
    .fault_o(fault_o)
  );
endmodule

// File: tb/tb_pump_ctrl.sv
module tb_pump_ctrl;
  localparam int unsigned CNT_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W-1:0] dwell = 4'd3;
  logic [3:0] vec = 4'b0000;  // {tank_hi, tank_lo, cis_hi, cis_lo}
  logic pump_on, lockout, fault;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pump_ctrl #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .dwell_i(dwell),
    .tank_hi_i(vec[3]), .tank_lo_i(vec[2]), .cis_hi_i(vec[1]), .cis_lo_i(vec[0]),
    .pump_on_o(pump_on), .lockout_o(lockout), .fault_o(fault)
  );

  // next {pump, lock, fault} from the requirements
  function automatic logic [2:0] step(input logic [2:0] st, input logic [3:0] v);
    logic p, l, th, tl, ch, cl, ln, pn;
    p = st[2]; l = st[1];
    th = v[3]; tl = v[2]; ch = v[1]; cl = v[0];
    if ((th && !tl) || (ch && !cl)) return {1'b0, l, 1'b1};
    ln = ch ? 1'b0 : (!cl ? 1'b1 : l);
    pn = p ? !(th || ln) : (!tl && !ln);
    return {pn, ln, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [2:0] exp);
    checks++;
    if ({pump_on, lockout, fault} !== exp) begin
      fails++;
      $display("FAIL %s: {pump,lock,fault} actual %b expected %b (vec %b)",
               tag, {pump_on, lockout, fault}, exp, vec);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    vec = 4'b0000;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle(input logic [3:0] v);
    vec = v;
    repeat (int'(dwell) + 8) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] st;
    do_reset();
    check("R1 reset", 3'b010);

    // R2 exact latency at dwell 3: visible at edge D+3
    vec = 4'b0011;
    repeat (5) @(negedge clk);
    check("R2 before edge D+3", 3'b010);
    @(negedge clk);
    check("R2 at edge D+3", 3'b100);

    // hysteresis walk
    settle(4'b0111); check("R7 tank mid keeps running", 3'b100);
    settle(4'b1111); check("R5 tank full stops", 3'b000);
    settle(4'b0111); check("R6 tank mid stays off", 3'b000);
    settle(4'b0011); check("R4 tank dry restarts", 3'b100);

    // R3 short pulse on tank high, dwell-1 cycles
    vec = 4'b1111;
    repeat (2) @(negedge clk);
    vec = 4'b0011;
    repeat (12) @(negedge clk);
    check("R3 short pulse ignored", 3'b100);

    settle(4'b0001); check("R7 cistern mid keeps running", 3'b100);
    settle(4'b0000); check("R8 cistern empty locks", 3'b010);
    settle(4'b0001); check("R9 low wet keeps lock", 3'b010);
    settle(4'b0011); check("R9 full releases, R4 start", 3'b100);
    settle(4'b1011); check("R10 tank fault", 3'b001);
    settle(4'b0011); check("R10 fault clears", 3'b100);
    settle(4'b0000); check("R8 lock again", 3'b010);
    settle(4'b0010); check("R10 cistern fault holds lock", 3'b011);
    settle(4'b0001); check("R10 fault exit keeps lock", 3'b010);

    // R11 dwell 0 same as 1: visible at edge 4
    dwell = 4'd0;
    do_reset();
    vec = 4'b0011;
    repeat (3) @(negedge clk);
    check("R11 dwell0 before edge 4", 3'b010);
    @(negedge clk);
    check("R11 dwell0 at edge 4", 3'b100);

    // sweep every ordered pair of vectors from reset
    dwell = 4'd3;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        st = 3'b010;
        settle(4'(a));
        for (int k = 0; k < 4; k++) st = step(st, 4'(a));
        check("R4 R5 R8 R9 R10 sweep first", st);
        settle(4'(b));
        for (int k = 0; k < 4; k++) st = step(st, 4'(b));
        check("R5 R6 R7 R9 R10 sweep second", st);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule